// File: doc/BRIEF.md
# Trigger-Latency Sample Pipeline with Event Derandomizer

This block serves one readout channel. On every crossing clock it stores one 18-bit sample in a circular pipeline of 200 entries. Bits 15:0 of a sample are data and bits 17:16 are error flags. The pipeline holds samples long enough for the level-1 trigger decision to arrive.

When an accept arrives, the block copies a window of consecutive samples out of the pipeline, one per clock, into a free slot of a 44-slot derandomizer. The window starts a programmable number of crossings before the accept. With the slot it records:
- the event number,
- the crossing number,
- the window length,
- a marker showing whether an earlier accept was lost.

Stored events leave in accept order as a stream of 16-bit words with a valid/ready handshake. The order is: event number, header, the data words, a saturating sum of the data, and an address/error word. A full output shows when all slots hold unread events.

Top module: `trig_pipe_derand`

## Requirements
- R1: For an accept sampled in crossing T with latency L, the data words are the 16-bit data of the samples written in crossings T-L, T-L+1, …, T-L+N-1, where L is the latency input, except that values above 199 act as 199.
- R2: The window length N is winLen, except that 0 gives 1 and values above 10 give 10. Each event is exactly N+4 words long.
- R3: Word 0 of each event is the event number. The event number counts every accept since reset, including dropped accepts, starting at 0.
- R4: Word 1 is the header word:
  - bits 11:0 hold the bxIn value sampled with the accept;
  - bits 13:12 are 0;
  - bit 14 is the lost-accept marker;
  - bit 15 is 1 when any captured sample had an error bit set.
- R5: Word N+2 is the sum of the N data words. The sum saturates at 0xFFFF.
- R6: Word N+3 is the address/error word:
  - bits 15:8 hold the channel identifier parameter (default 0x5A);
  - bits 7:4 hold N;
  - bits 3:2 are 0;
  - bits 1:0 are the bitwise OR of the error bits of the captured samples.
- R7: Up to 44 events are stored. full is 1 exactly while 44 unread events are stored. An accept that arrives while full is 1 stores nothing.
- R8: An accept that arrives while a window copy is still in progress (within N crossings after a taken accept) stores nothing, and it does not disturb the copy in progress.
- R9: After one or more accepts are dropped, bit 14 of the header is 1 in the next stored event and 0 in the events after it.
- R10: Events leave in accept order. outValid is 0 when no event is stored. While outValid is 1 and outReady is 0, outData and outValid hold their values.
- R11: After reset no event is stored, and both outValid and full are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 18 | Sample for this crossing: error flags in bits 17:16, data in bits 15:0 |
| l1Accept | input | 1 | Level-1 accept for this crossing |
| bxIn | input | 12 | Crossing number, stored with the accept |
| latency | input | 8 | Distance from the accept back to the first sample of the window |
| winLen | input | 4 | Requested window length |
| outData | output | 16 | Event word |
| outValid | output | 1 | outData holds a word |
| outReady | input | 1 | Consumer takes the word on this clock |
| full | output | 1 | All derandomizer slots are occupied |

## Verification
The embedded properties are checked on every cycle. They cover:
- that the slot count never passes its limit;
- that a copy in progress keeps its length when another accept arrives;
- that the readout sits at its start word whenever nothing is stored;
- that the running sum never falls while data words are consumed;
- that a stalled output word holds still.

The bench scenarios cover what needs a stimulus history:
- the exact sample window at several latencies, including zero and the clamped maximum;
- window-length clamping;
- saturation of the sum;
- the error OR fields;
- event numbering across dropped accepts;
- the lost-accept marker appearing once after both busy and full drops;
- strict order of a full derandomizer.

// File: rtl/tpd_pkg.sv
`timescale 1ns/1ps
package tpd_pkg;
  localparam int WORD_W = 16;
  localparam int ERR_W  = 2;
  localparam int SMP_W  = WORD_W + ERR_W;

  typedef enum logic [2:0] {
    PH_EVT  = 3'd0,
    PH_HDR  = 3'd1,
    PH_DATA = 3'd2,
    PH_SUM  = 3'd3,
    PH_TAIL = 3'd4
  } phase_e;

  typedef struct packed {
    logic capStart;  // accept taken: latch metadata and start address
    logic capWr;     // copy one sample from pipeline to slot
    logic capLast;   // final copy cycle: commit error OR
    logic ovfMark;   // lost-accept marker for the event being started
    logic sumClr;    // header word consumed: clear running sum
    logic sumAdd;    // data word consumed: accumulate
  } strobe_t;

  function automatic logic [WORD_W-1:0] satAdd(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[WORD_W] ? {WORD_W{1'b1}} : s[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/tpd_ctrl.sv
`timescale 1ns/1ps
module tpd_ctrl import tpd_pkg::*; #(
  parameter int NUM_BUF = 44,
  parameter int WIN_MAX = 10,
  localparam int SLOT_W = $clog2(NUM_BUF),
  localparam int LEN_W  = $clog2(WIN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              l1Accept,
  input  logic [LEN_W-1:0]  winLen,
  input  logic              outReady,
  input  logic [LEN_W-1:0]  rdLen,
  output strobe_t           strb,
  output logic [LEN_W-1:0]  capN,
  output logic [SLOT_W-1:0] capSlot,
  output logic [LEN_W-1:0]  capIdx,
  output logic [SLOT_W-1:0] rdSlot,
  output logic [LEN_W-1:0]  rdIdx,
  output phase_e            phase,
  output logic              outValid,
  output logic              full
);
  localparam int CNT_W = $clog2(NUM_BUF + 1);

  logic              capBusy;
  logic [LEN_W-1:0]  capLen;
  logic [SLOT_W-1:0] wrBuf, rdBuf;
  logic [CNT_W-1:0]  count;
  logic              dropPending;
  logic              accOk, dropNow, lastWr, hs, pop;

  // clamp requested window to 1..WIN_MAX
  always_comb begin
    if (winLen == '0)                    capN = LEN_W'(1);
    else if (winLen > LEN_W'(WIN_MAX))   capN = LEN_W'(WIN_MAX);
    else                                 capN = winLen;
  end

  assign full     = (count == CNT_W'(NUM_BUF));
  assign outValid = (count != '0);
  assign capSlot  = wrBuf;
  assign rdSlot   = rdBuf;

  assign accOk   = l1Accept && !capBusy && !full;
  assign dropNow = l1Accept && !accOk;
  assign lastWr  = capBusy && (capIdx == capLen - 1'b1);
  assign hs      = outValid && outReady;
  assign pop     = hs && (phase == PH_TAIL);

  always_comb begin
    strb          = '0;
    strb.capStart = accOk;
    strb.capWr    = capBusy;
    strb.capLast  = lastWr;
    strb.ovfMark  = dropPending;
    strb.sumClr   = hs && (phase == PH_HDR);
    strb.sumAdd   = hs && (phase == PH_DATA);
  end

  // capture sequencing and slot bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capBusy     <= 1'b0;
      capIdx      <= '0;
      capLen      <= LEN_W'(1);
      wrBuf       <= '0;
      dropPending <= 1'b0;
      count       <= '0;
    end else begin
      if (accOk) begin
        capBusy     <= 1'b1;
        capIdx      <= '0;
        capLen      <= capN;
        dropPending <= 1'b0;
      end else if (lastWr) begin
        capBusy <= 1'b0;
        wrBuf   <= (wrBuf == SLOT_W'(NUM_BUF - 1)) ? '0 : wrBuf + 1'b1;
      end else if (capBusy) begin
        capIdx <= capIdx + 1'b1;
      end
      if (dropNow) dropPending <= 1'b1;
      count <= count + CNT_W'(lastWr) - CNT_W'(pop);
    end
  end

  // readout word sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_EVT;
      rdIdx <= '0;
      rdBuf <= '0;
    end else if (hs) begin
      case (phase)
        PH_EVT:  phase <= PH_HDR;
        PH_HDR: begin
          phase <= PH_DATA;
          rdIdx <= '0;
        end
        PH_DATA: begin
          if (rdIdx == rdLen - 1'b1) phase <= PH_SUM;
          else                       rdIdx <= rdIdx + 1'b1;
        end
        PH_SUM:  phase <= PH_TAIL;
        default: begin
          phase <= PH_EVT;
          rdBuf <= (rdBuf == SLOT_W'(NUM_BUF - 1)) ? '0 : rdBuf + 1'b1;
        end
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(NUM_BUF));

  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capBusy && !lastWr && l1Accept) |=> (capBusy && $stable(capLen)));

  // R2
  cap_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    capBusy |-> (capLen != '0 && capLen <= LEN_W'(WIN_MAX) && capIdx < capLen));

  // R10
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> (phase == PH_EVT));
endmodule

// File: rtl/tpd_datapath.sv
`timescale 1ns/1ps
module tpd_datapath import tpd_pkg::*; #(
  parameter int          PIPE_DEPTH = 200,
  parameter int          NUM_BUF    = 44,
  parameter int          WIN_MAX    = 10,
  parameter int          BX_W       = 12,
  parameter logic [7:0]  CHAN_ID    = 8'h5A,
  localparam int PTR_W  = $clog2(PIPE_DEPTH),
  localparam int SLOT_W = $clog2(NUM_BUF),
  localparam int LEN_W  = $clog2(WIN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SMP_W-1:0]  sampleIn,
  input  logic              l1Accept,
  input  logic [PTR_W-1:0]  latency,
  input  logic [BX_W-1:0]   bxIn,
  input  strobe_t           strb,
  input  logic [LEN_W-1:0]  capN,
  input  logic [SLOT_W-1:0] capSlot,
  input  logic [LEN_W-1:0]  capIdx,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [LEN_W-1:0]  rdIdx,
  input  phase_e            phase,
  output logic [LEN_W-1:0]  rdLen,
  output logic [WORD_W-1:0] outData
);
  localparam int SLOTS_X_WIN = NUM_BUF * WIN_MAX;
  localparam int ADDR_W      = $clog2(SLOTS_X_WIN);

  logic [SMP_W-1:0]  pipeMem [PIPE_DEPTH];
  logic [WORD_W-1:0] bufMem  [SLOTS_X_WIN];
  logic [WORD_W-1:0] metaEvt [NUM_BUF];
  logic [BX_W-1:0]   metaBx  [NUM_BUF];
  logic [LEN_W-1:0]  metaLen [NUM_BUF];
  logic              metaOvf [NUM_BUF];
  logic [ERR_W-1:0]  metaErr [NUM_BUF];

  logic [PTR_W-1:0]  wrPtr, capRd, startAddr;
  logic [ERR_W-1:0]  errAcc;
  logic [WORD_W-1:0] evtCnt, sumAcc;
  logic [SMP_W-1:0]  pipeRd;
  logic [ADDR_W-1:0] capAddr, rdAddr;
  logic [WORD_W-1:0] rdData, hdrWord, tailWord;

  // start of window: write pointer minus clamped latency, modulo depth
  always_comb begin
    int latI, wrI, startI;
    latI = (int'(latency) > PIPE_DEPTH - 1) ? PIPE_DEPTH - 1 : int'(latency);
    wrI  = int'(wrPtr);
    startI = (wrI >= latI) ? (wrI - latI) : (wrI + PIPE_DEPTH - latI);
    startAddr = PTR_W'(startI);
  end

  assign pipeRd  = pipeMem[capRd];
  assign capAddr = ADDR_W'(capSlot) * ADDR_W'(WIN_MAX) + ADDR_W'(capIdx);
  assign rdAddr  = ADDR_W'(rdSlot) * ADDR_W'(WIN_MAX) + ADDR_W'(rdIdx);
  assign rdData  = bufMem[rdAddr];
  assign rdLen   = metaLen[rdSlot];

  // storage arrays (no reset needed: read only after commit)
  always_ff @(posedge clk) begin
    pipeMem[wrPtr] <= sampleIn;
    if (strb.capWr) bufMem[capAddr] <= pipeRd[WORD_W-1:0];
    if (strb.capStart) begin
      metaEvt[capSlot] <= evtCnt;
      metaBx[capSlot]  <= bxIn;
      metaLen[capSlot] <= capN;
      metaOvf[capSlot] <= strb.ovfMark;
    end
    if (strb.capLast) metaErr[capSlot] <= errAcc | pipeRd[SMP_W-1:WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      capRd  <= '0;
      errAcc <= '0;
      evtCnt <= '0;
      sumAcc <= '0;
    end else begin
      wrPtr <= (wrPtr == PTR_W'(PIPE_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (l1Accept) evtCnt <= evtCnt + 1'b1;
      if (strb.capStart) begin
        capRd  <= startAddr;
        errAcc <= '0;
      end else if (strb.capWr) begin
        capRd  <= (capRd == PTR_W'(PIPE_DEPTH - 1)) ? '0 : capRd + 1'b1;
        errAcc <= errAcc | pipeRd[SMP_W-1:WORD_W];
      end
      if (strb.sumClr)      sumAcc <= '0;
      else if (strb.sumAdd) sumAcc <= satAdd(sumAcc, rdData);
    end
  end

  always_comb begin
    hdrWord             = '0;
    hdrWord[BX_W-1:0]   = metaBx[rdSlot];
    hdrWord[14]         = metaOvf[rdSlot];
    hdrWord[15]         = |metaErr[rdSlot];
    tailWord = {CHAN_ID, 4'(metaLen[rdSlot]), 2'b00, metaErr[rdSlot]};
    case (phase)
      PH_EVT:  outData = metaEvt[rdSlot];
      PH_HDR:  outData = hdrWord;
      PH_DATA: outData = rdData;
      PH_SUM:  outData = sumAcc;
      default: outData = tailWord;
    endcase
  end

  // R5
  sum_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sumAdd |=> (sumAcc >= $past(sumAcc)));
endmodule

// File: rtl/trig_pipe_derand.sv
`timescale 1ns/1ps
module trig_pipe_derand import tpd_pkg::*; #(
  parameter int          PIPE_DEPTH = 200,
  parameter int          NUM_BUF    = 44,
  parameter int          WIN_MAX    = 10,
  parameter int          BX_W       = 12,
  parameter logic [7:0]  CHAN_ID    = 8'h5A,
  localparam int PTR_W = $clog2(PIPE_DEPTH),
  localparam int LEN_W = $clog2(WIN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SMP_W-1:0]  sampleIn,
  input  logic              l1Accept,
  input  logic [BX_W-1:0]   bxIn,
  input  logic [PTR_W-1:0]  latency,
  input  logic [LEN_W-1:0]  winLen,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              full
);
  localparam int SLOT_W = $clog2(NUM_BUF);

  strobe_t           strb;
  logic [LEN_W-1:0]  capN, capIdx, rdIdx, rdLen;
  logic [SLOT_W-1:0] capSlot, rdSlot;
  phase_e            phase;

  tpd_ctrl #(.NUM_BUF(NUM_BUF), .WIN_MAX(WIN_MAX)) ctrlU (
    .clk(clk), .rstN(rstN), .l1Accept(l1Accept), .winLen(winLen),
    .outReady(outReady), .rdLen(rdLen), .strb(strb), .capN(capN),
    .capSlot(capSlot), .capIdx(capIdx), .rdSlot(rdSlot), .rdIdx(rdIdx),
    .phase(phase), .outValid(outValid), .full(full)
  );

  tpd_datapath #(.PIPE_DEPTH(PIPE_DEPTH), .NUM_BUF(NUM_BUF), .WIN_MAX(WIN_MAX),
                 .BX_W(BX_W), .CHAN_ID(CHAN_ID)) dataU (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .l1Accept(l1Accept),
    .latency(latency), .bxIn(bxIn), .strb(strb), .capN(capN),
    .capSlot(capSlot), .capIdx(capIdx), .rdSlot(rdSlot), .rdIdx(rdIdx),
    .phase(phase), .rdLen(rdLen), .outData(outData)
  );

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: tb/trig_pipe_derand_test.sv
`timescale 1ns/1ps
module trig_pipe_derand_test;
  localparam int HMAX = 16384;
  localparam int NV = 8;
  // latency, winLen, sample pattern
  localparam int VEC [NV][3] = '{
    '{30, 10, 0}, '{0, 10, 0}, '{199, 3, 0}, '{255, 10, 2},
    '{12, 0, 0},  '{15, 14, 0}, '{20, 10, 1}, '{40, 7, 0}};

  logic clk = 1'b0, rstN = 1'b0;
  logic [17:0] sampleIn = '0;
  logic l1Accept = 1'b0;
  logic [11:0] bxIn = '0;
  logic [7:0] latency = 8'd30;
  logic [3:0] winLen = 4'd10;
  logic outReady = 1'b0;
  logic [15:0] outData;
  logic outValid, full;

  trig_pipe_derand uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .l1Accept(l1Accept),
    .bxIn(bxIn), .latency(latency), .winLen(winLen), .outData(outData),
    .outValid(outValid), .outReady(outReady), .full(full));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int n = 0, mode = 0, accAtReg = 0, accCount = 0;
  bit accReq = 1'b0;
  logic [17:0] hist [0:HMAX-1];
  logic [15:0] got [0:15];
  int atArr [0:63];
  int idArr [0:63];

  function automatic logic [17:0] gen(int k, int m);
    logic [15:0] d;
    logic [1:0] e;
    case (m)
      1: begin d = 16'hE000 | 16'(k & 255); e = 2'b00; end
      2: begin d = 16'(k & 255); e = 2'b00; end
      default: begin
        d = 16'(k * 37 + 11);
        e = (k % 23 == 5) ? 2'b10 : ((k % 29 == 3) ? 2'b01 : 2'b00);
      end
    endcase
    return {e, d};
  endfunction

  // single driver of samples, crossing number and accept
  always @(negedge clk) begin
    logic [17:0] v;
    v = gen(n, mode);
    hist[n % HMAX] = v;
    sampleIn = v;
    bxIn = 12'(n + 12'h300);
    l1Accept = accReq;
    if (accReq) begin
      accAtReg = n;
      accReq = 1'b0;
    end
    n++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic fireAccept(output int at, output int id);
    @(posedge clk); #1;
    accReq = 1'b1;
    @(posedge clk); #1;
    at = accAtReg;
    id = accCount;
    accCount++;
  endtask

  task automatic readEvent(input int nw, output int k);
    int guard;
    @(posedge clk); #1;
    outReady = 1'b1;
    k = 0;
    guard = 0;
    while (k < nw && guard < 2000) begin
      @(negedge clk);
      if (outValid) begin
        got[k] = outData;
        k++;
      end
      guard++;
    end
    @(posedge clk); #1;
    outReady = 1'b0;
  endtask

  task automatic checkEvent(int at, int lat, int win, int id, bit ovf);
    int le, ne, k, sum, hdr, tail;
    logic [1:0] errOr;
    logic [17:0] smp;
    le = (lat > 199) ? 199 : lat;
    ne = (win == 0) ? 1 : ((win > 10) ? 10 : win);
    readEvent(ne + 4, k);
    chk(k == ne + 4, "R2 word count", k, ne + 4);
    if (k != ne + 4) return;
    chk(got[0] == 16'(id), "R3 event number", got[0], id);
    sum = 0;
    errOr = 2'b00;
    for (int j = 0; j < ne; j++) begin
      smp = hist[(at - le + j) % HMAX];
      chk(got[2 + j] == smp[15:0], "R1 window data", got[2 + j], smp[15:0]);
      sum += int'(smp[15:0]);
      errOr |= smp[17:16];
    end
    if (sum > 65535) sum = 65535;
    hdr = ((errOr != 2'b00) ? 32768 : 0) + (ovf ? 16384 : 0) + ((at + 768) & 4095);
    chk(got[1] == 16'(hdr), "R4 R9 header", got[1], hdr);
    chk(got[ne + 2] == 16'(sum), "R5 sum", got[ne + 2], sum);
    tail = (8'h5A << 8) | (ne << 4) | int'(errOr);
    chk(got[ne + 3] == 16'(tail), "R6 address/error", got[ne + 3], tail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R10 watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int at, id, aA, iA, aC, iC, dummyA, dummyI;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R11 outValid after reset", outValid, 0);
    chk(full == 1'b0, "R11 full after reset", full, 0);
    repeat (250) @(posedge clk);

    // vector table: latency / window / pattern
    for (int v = 0; v < NV; v++) begin
      @(posedge clk); #1;
      latency = 8'(VEC[v][0]);
      winLen = 4'(VEC[v][1]);
      mode = VEC[v][2];
      repeat (210) @(posedge clk);
      fireAccept(at, id);
      repeat (14) @(posedge clk);
      checkEvent(at, VEC[v][0], VEC[v][1], id, 1'b0);
    end
    mode = 0;

    // R10 backpressure: word held while not ready
    @(posedge clk); #1;
    latency = 8'd30;
    winLen = 4'd4;
    fireAccept(at, id);
    repeat (10) @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(outValid == 1'b1, "R10 valid held", outValid, 1);
      chk(outData == 16'(id), "R10 word held", outData, id);
    end
    checkEvent(at, 30, 4, id, 1'b0);

    // R8 accept during copy dropped, R9 marker on next event
    @(posedge clk); #1;
    winLen = 4'd10;
    fireAccept(aA, iA);
    repeat (2) @(posedge clk);
    fireAccept(dummyA, dummyI);
    repeat (15) @(posedge clk);
    fireAccept(aC, iC);
    repeat (14) @(posedge clk);
    checkEvent(aA, 30, 10, iA, 1'b0);
    checkEvent(aC, 30, 10, iC, 1'b1);
    @(negedge clk);
    chk(outValid == 1'b0, "R8 dropped accept stored nothing", outValid, 0);

    // R7 fill all slots
    @(posedge clk); #1;
    latency = 8'd5;
    winLen = 4'd2;
    for (int i = 0; i < 44; i++) begin
      fireAccept(atArr[i], idArr[i]);
      repeat (3) @(posedge clk);
      if (i == 42) begin
        @(negedge clk);
        chk(full == 1'b0, "R7 not full at 43", full, 0);
      end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(full == 1'b1, "R7 full at 44", full, 1);
    fireAccept(dummyA, dummyI);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(full == 1'b1, "R7 full after dropped accept", full, 1);
    for (int i = 0; i < 44; i++) begin
      checkEvent(atArr[i], 5, 2, idArr[i], 1'b0);
      if (i == 0) begin
        @(negedge clk);
        chk(full == 1'b0, "R7 full clears after one event read", full, 0);
      end
    end
    @(negedge clk);
    chk(outValid == 1'b0, "R7 accept while full stored nothing", outValid, 0);

    // R9 marker appears once
    fireAccept(aA, iA);
    repeat (6) @(posedge clk);
    checkEvent(aA, 5, 2, iA, 1'b1);
    fireAccept(aC, iC);
    repeat (6) @(posedge clk);
    checkEvent(aC, 5, 2, iC, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule